// File: doc/BRIEF.md
# Serial-In Shift Register with Latched Parallel Outputs

This block turns a serial bit stream into a parallel word. It has two stages: a shift stage that takes one serial bit on each rising edge of a shift strobe, and a storage stage that copies the whole shift stage on a rising edge of a separate storage strobe. The storage stage drives the parallel outputs. Because the two stages are separate, new data can be shifted in while the outputs keep the previous word. The outputs change only when the storage strobe is pulsed.

Both strobes are level inputs sampled by the system clock. A strobe counts as an edge in the cycle where it is seen high after being low. An active-low clear forces the shift stage to zero and has priority over shifting. An active-low output enable switches the parallel outputs to high impedance. A drive-enable output lets a pad cell follow the same control. The last shift stage also leaves the block on a cascade output, so several units can be chained behind one serial master.

Top module: `sipo_latch`

## Requirements
- R1: After reset both stages hold zero. With `oe_n_i` low, `pout_o` is 0, `pout_drv_o` is 1 and `cascade_o` is 0.
- R2: The shift stage moves exactly once per rising edge of `shck_i`. Bit 0 (first stage) takes `sdi_i`, and each bit i takes the old bit i-1. A strobe held high for several cycles gives one shift.
- R3: `pout_o` changes only in the cycle after a rising edge of `rck_i`. It then shows the shift stage contents.
- R4: Eight bits shifted most significant bit first and then stored appear on `pout_o` as that byte, with the first bit at `pout_o[7]`.
- R5: With `oe_n_i` high, `pout_drv_o` is 0 and `pout_o` is high impedance. The stored word is kept and shows again once `oe_n_i` returns low.
- R6: While `clr_n_i` is low, the shift stage becomes zero, even when a shift edge arrives in the same cycle. The storage stage is not affected; a later store transfers zero.
- R7: `cascade_o` always shows the last shift stage (bit 7). After eight shifts it equals the first bit shifted in.
- R8: When shift and store edges fall in the same cycle, the storage stage captures the shift contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sdi_i | input | 1 | Serial data in |
| shck_i | input | 1 | Shift strobe, acts on its rising edge |
| rck_i | input | 1 | Storage strobe, acts on its rising edge |
| clr_n_i | input | 1 | Active-low clear of the shift stage |
| oe_n_i | input | 1 | Active-low output enable |
| pout_o | output | 8 | Parallel outputs, high impedance when disabled |
| pout_drv_o | output | 1 | High while the parallel outputs are driven |
| cascade_o | output | 1 | Last shift stage, for chaining |

## Verification
The shift edge and the store edge can both be detected in one cycle. The bench provokes this by raising both strobes on the same clock while loading the eighth bit of a word. The stored word must then equal the shift contents after seven shifts, not the complete byte. A second store then shows the complete byte. Clear and a shift edge in the same cycle are judged the same way: the shift stage must read zero and the stored word must be unchanged.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  typedef struct packed {
    logic shift;
    logic store;
  } strobe_evt_t;

  function automatic logic rose(input logic now, input logic prev);
    return now & ~prev;
  endfunction
endpackage

// File: rtl/sipo_edge_det.sv
module sipo_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  import sipo_pkg::*;
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = rose(lvl_i[g], prev_q[g]);
  end
endmodule

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         clr_n_i,
  input  logic         sdi_i,
  output logic [W-1:0] sr_o
);
  function automatic logic [W-1:0] shift_in(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (!clr_n_i) sr_q <= '0;
    else if (shift_i)  sr_q <= shift_in(sr_q, sdi_i);
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/sipo_store_stage.sv
module sipo_store_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         store_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= '0;
    else if (store_i) st_q <= d_i;
  end

  assign q_o = st_q;
endmodule

// File: rtl/sipo_out_drv.sv
module sipo_out_drv #(
  parameter int W = 8
) (
  input  logic         oe_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] pad_o,
  output logic         drv_o
);
  assign drv_o = ~oe_n_i;
  for (genvar g = 0; g < W; g++) begin : g_pad
    assign pad_o[g] = drv_o ? d_i[g] : 1'bz;
  end
endmodule

// File: rtl/sipo_latch.sv
module sipo_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdi_i,
  input  logic         shck_i,
  input  logic         rck_i,
  input  logic         clr_n_i,
  input  logic         oe_n_i,
  output logic [W-1:0] pout_o,
  output logic         pout_drv_o,
  output logic         cascade_o
);
  import sipo_pkg::*;
  localparam int NSTROBE = 2;
  localparam int MSB = W - 1;

  logic [NSTROBE-1:0] rise;
  strobe_evt_t        evt;
  logic               shift_evt;
  logic               store_evt;
  logic [W-1:0]       sr_q;
  logic [W-1:0]       st_q;

  sipo_edge_det #(.N(NSTROBE)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl_i({shck_i, rck_i}),
    .rise_o(rise)
  );

  assign evt       = strobe_evt_t'(rise);
  assign shift_evt = evt.shift;
  assign store_evt = evt.store;

  sipo_shift_stage #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_i(shift_evt), .clr_n_i(clr_n_i), .sdi_i(sdi_i),
    .sr_o(sr_q)
  );

  sipo_store_stage #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .store_i(store_evt), .d_i(sr_q),
    .q_o(st_q)
  );

  sipo_out_drv #(.W(W)) u_drv (
    .oe_n_i(oe_n_i), .d_i(st_q),
    .pad_o(pout_o), .drv_o(pout_drv_o)
  );

  assign cascade_o = sr_q[MSB];
endmodule

// File: rtl/sipo_latch_chk.sv
module sipo_latch_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sdi_i,
  input logic         clr_n_i,
  input logic         shift_evt,
  input logic         store_evt,
  input logic [W-1:0] sr_q,
  input logic [W-1:0] st_q,
  input logic         cascade_o
);
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_i |=> sr_q == '0);

  assert_shift_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && clr_n_i) |=> sr_q == {$past(sr_q[W-2:0]), $past(sdi_i)});

  assert_no_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_evt && clr_n_i) |=> $stable(sr_q));

  assert_store_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> st_q == $past(sr_q));

  assert_store_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !store_evt |=> $stable(st_q));

  assert_cascade_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && clr_n_i) |=> cascade_o == $past(sr_q[W-2]));

  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && store_evt) |=> st_q == $past(sr_q));
endmodule

bind sipo_latch sipo_latch_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdi_i(sdi_i), .clr_n_i(clr_n_i),
  .shift_evt(shift_evt), .store_evt(store_evt),
  .sr_q(sr_q), .st_q(st_q), .cascade_o(cascade_o)
);

// File: tb/sipo_latch_tb.sv
module sipo_latch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdi = 1'b0, shck = 1'b0, rck = 1'b0, clr_n = 1'b1, oe_n = 1'b0;
  logic [7:0] pout;
  logic drv, casc;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sipo_latch u_dut (
    .clk(clk), .rst_n(rst_n), .sdi_i(sdi), .shck_i(shck), .rck_i(rck),
    .clr_n_i(clr_n), .oe_n_i(oe_n), .pout_o(pout), .pout_drv_o(drv),
    .cascade_o(casc)
  );

  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{8'hA5, 8'h3C, 8'h80, 8'h01, 8'hFF, 8'h00};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    sdi = b; shck = 1'b1; tick();
    shck = 1'b0; tick();
  endtask

  task automatic store();
    rck = 1'b1; tick();
    rck = 1'b0; tick();
  endtask

  task automatic load_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) shift_bit(v[i]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    tick(); tick();
    // R1 reset state
    chk("R1 pout", pout, 8'h00);
    chk("R1 drv", {7'd0, drv}, 8'h01);
    chk("R1 cascade", {7'd0, casc}, 8'h00);
    rst_n = 1'b1; tick();

    // vector table: R3 hold, R7 cascade, R4 result
    prev = 8'h00;
    for (int k = 0; k < NV; k++) begin
      load_byte(VEC[k]);
      chk("R3 hold before store", pout, prev);
      chk("R7 cascade first bit", {7'd0, casc}, {7'd0, VEC[k][7]});
      store();
      chk("R4 byte msb first", pout, VEC[k]);
      prev = VEC[k];
    end

    // R2 held strobe shifts once
    clr_n = 1'b0; tick(); clr_n = 1'b1; tick();
    shift_bit(1'b1);
    sdi = 1'b0; shck = 1'b1; tick(); tick(); tick();
    shck = 1'b0; tick();
    store();
    chk("R2 one shift per edge", pout, 8'h02);

    // R8 simultaneous shift and store
    load_byte(8'h5A); store();
    for (int i = 7; i >= 1; i--) shift_bit(8'hC3 >> i);
    sdi = 1'b1; shck = 1'b1; rck = 1'b1; tick();
    shck = 1'b0; rck = 1'b0; tick();
    chk("R8 pre-shift captured", pout, 8'h61);
    store();
    chk("R8 full byte after", pout, 8'hC3);

    // R6 clear with shift edge in same cycle, storage unaffected
    sdi = 1'b1; shck = 1'b1; clr_n = 1'b0; tick();
    shck = 1'b0; clr_n = 1'b1; tick();
    chk("R6 storage kept", pout, 8'hC3);
    chk("R6 cascade zero", {7'd0, casc}, 8'h00);
    store();
    chk("R6 store after clear", pout, 8'h00);

    // R5 output enable
    load_byte(8'h96); store();
    oe_n = 1'b1; tick();
    chk("R5 drive off", {7'd0, drv}, 8'h00);
    tick(); tick();
    oe_n = 1'b0; tick();
    chk("R5 drive on", {7'd0, drv}, 8'h01);
    chk("R5 storage kept", pout, 8'h96);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule